// File: doc/BRIEF.md
# Substrate Shutter Pulse Generator

This block produces the electronic-shutter substrate clock inside a CCD timing engine. It counts pixel clocks within each line and lines within each field, restarting on the horizontal and vertical sync strobes. In every field it emits a string of pulses, at most one per line. The string starts on the line just after a programmable sense-gate line. The number of pulses in the string sets the exposure time.

The settings are the polarity, the set and clear pixel positions, the pulse count and a suppress flag. They arrive on staged configuration inputs. The block copies them into its working copy only on the sync strobe that opens the line after the sense-gate line. A value written while a string is running therefore first affects the next field. The sense-gate line number is compared directly, without staging.

Top module: `shutter_pulse_gen`

## Requirements
- R1: Reset sets the output low, which is the inactive level of the default active-high polarity. No pulse appears until a sync strobe has opened the line after the sense-gate line.
- R2: The first pulse of a string falls in the line numbered sense-gate line + 1. Lines are numbered from 0, and line 0 is the line opened by `vsync`. Each `hsync` strobe opens the next line.
- R3: Pulses fall in consecutive lines, and there are exactly as many as the staged pulse count. A count of 0 gives no pulse.
- R4: A line carries at most one pulse. The pixel counter reads 0 in the cycle after the line's sync strobe and then counts up. The output is active in the cycles in which the pixel counter reads set+1 through clear, which is clear−set cycles.
- R5: When the set and clear positions are equal, no pulse is produced.
- R6: `cfg_pol` = 1 selects an active-high output that idles low. `cfg_pol` = 0 selects an active-low output that idles high.
- R7: A `vsync` strobe ends any unfinished string. Lines past the end of the field lose their pulses, and the next field carries no leftover pulses before its own start line.
- R8: When the suppress flag is 1 at the start of a string, that field carries no pulse and the output stays at its inactive level.
- R9: A change on the staged inputs during a field leaves the rest of that field unchanged. The change takes effect at the start of the line after the sense-gate line in the following field.
- R10: With unchanged settings, each field repeats the same pulse string.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | One-cycle strobe that opens a new line |
| vsync | input | 1 | One-cycle strobe that opens line 0 of a field |
| cfg_pol | input | 1 | Staged polarity: 1 active-high, 0 active-low |
| cfg_tog_set | input | PIX_W | Staged pixel position that starts the pulse |
| cfg_tog_clr | input | PIX_W | Staged pixel position that ends the pulse |
| cfg_pulse_cnt | input | CNT_W | Staged number of pulse lines per field |
| cfg_suppress | input | 1 | Staged flag that skips the field's string |
| cfg_sg_line | input | LINE_W | Sense-gate line number, used directly |
| sub_out | output | 1 | Substrate shutter output |

## Verification
The hardest case to reach is a staged write that lands in the middle of a running string. The bench changes the settings while the string is on its second line. It then checks that the current field keeps the old pulse width on every remaining line, and that the new width appears only in the following field. The second hard case is a string cut short by the end of the field. The bench places the sense-gate line near the last line, so the count overruns the field, and then checks that the next field stays quiet up to its start line.

// File: rtl/spg_pkg.sv
`timescale 1ns/1ps
package spg_pkg;
   localparam int unsigned SPG_MIN_W = 2;

   typedef enum logic {
      SPG_WRAP = 1'b0,
      SPG_SAT  = 1'b1
   } spg_cnt_mode_e;

   function automatic logic spg_level(input logic act, input logic pol);
      return act ? pol : ~pol;
   endfunction
endpackage

// File: rtl/spg_timebase.sv
`timescale 1ns/1ps
module spg_timebase #(
   parameter int unsigned PIX_W = 8,
   parameter int unsigned LINE_W = 10,
   parameter spg_pkg::spg_cnt_mode_e PIX_MODE = spg_pkg::SPG_SAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync,
   input  logic              vsync,
   output logic [PIX_W-1:0]  pix_q,
   output logic [LINE_W-1:0] line_q
);
   localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
   localparam logic [LINE_W-1:0] LINE_MAX = '1;

   logic [PIX_W-1:0]  pix_inc;
   logic [LINE_W-1:0] line_inc;

   generate
      if (PIX_MODE == spg_pkg::SPG_SAT) begin : g_pix_sat
         assign pix_inc = (pix_q == PIX_MAX) ? pix_q : pix_q + 1'b1;
      end else begin : g_pix_wrap
         assign pix_inc = pix_q + 1'b1;
      end
   endgenerate

   assign line_inc = (line_q == LINE_MAX) ? line_q : line_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q  <= '0;
         line_q <= '0;
      end else if (vsync) begin
         pix_q  <= '0;
         line_q <= '0;
      end else if (hsync) begin
         pix_q  <= '0;
         line_q <= line_inc;
      end else begin
         pix_q  <= pix_inc;
      end
   end
endmodule

// File: rtl/spg_shadow.sv
`timescale 1ns/1ps
module spg_shadow #(
   parameter int unsigned PIX_W = 8,
   parameter int unsigned LINE_W = 10,
   parameter int unsigned CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync,
   input  logic              vsync,
   input  logic [LINE_W-1:0] line_q,
   input  logic [LINE_W-1:0] sg_line,
   input  logic              stg_pol,
   input  logic [PIX_W-1:0]  stg_set,
   input  logic [PIX_W-1:0]  stg_clr,
   input  logic [CNT_W-1:0]  stg_cnt,
   input  logic              stg_sup,
   output logic              load,
   output logic              pol_s,
   output logic [PIX_W-1:0]  on_s,
   output logic [PIX_W-1:0]  off_s,
   output logic [CNT_W-1:0]  rem_q
);
   // the strobe that closes the sense-gate line opens the first string line
   assign load = hsync && !vsync && (line_q == sg_line);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_s <= 1'b1;
         on_s  <= '0;
         off_s <= '0;
      end else if (load) begin
         pol_s <= stg_pol;
         on_s  <= stg_set;
         off_s <= stg_clr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (vsync) begin
         rem_q <= '0;
      end else if (load) begin
         rem_q <= stg_sup ? '0 : stg_cnt;
      end else if (hsync && (rem_q != '0)) begin
         rem_q <= rem_q - 1'b1;
      end
   end
endmodule

// File: rtl/spg_edge.sv
`timescale 1ns/1ps
module spg_edge #(
   parameter int unsigned PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync,
   input  logic             vsync,
   input  logic             line_en,
   input  logic [PIX_W-1:0] pix_q,
   input  logic [PIX_W-1:0] on_s,
   input  logic [PIX_W-1:0] off_s,
   input  logic             pol_s,
   output logic             act_q,
   output logic             sub_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
      end else if (hsync || vsync || !line_en) begin
         act_q <= 1'b0;
      end else if (pix_q == off_s) begin
         act_q <= 1'b0;
      end else if (pix_q == on_s) begin
         act_q <= 1'b1;
      end
   end

   assign sub_out = spg_pkg::spg_level(act_q, pol_s);
endmodule

// File: rtl/shutter_pulse_gen.sv
`timescale 1ns/1ps
module shutter_pulse_gen #(
   parameter int unsigned PIX_W = 8,
   parameter int unsigned LINE_W = 10,
   parameter int unsigned CNT_W = 8,
   parameter spg_pkg::spg_cnt_mode_e PIX_MODE = spg_pkg::SPG_SAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync,
   input  logic              vsync,
   input  logic              cfg_pol,
   input  logic [PIX_W-1:0]  cfg_tog_set,
   input  logic [PIX_W-1:0]  cfg_tog_clr,
   input  logic [CNT_W-1:0]  cfg_pulse_cnt,
   input  logic              cfg_suppress,
   input  logic [LINE_W-1:0] cfg_sg_line,
   output logic              sub_out
);
   generate
      if (PIX_W < spg_pkg::SPG_MIN_W) begin : g_bad_pix
         $error("shutter_pulse_gen: PIX_W below minimum");
      end
      if (LINE_W < spg_pkg::SPG_MIN_W) begin : g_bad_line
         $error("shutter_pulse_gen: LINE_W below minimum");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("shutter_pulse_gen: CNT_W must be at least 1");
      end
   endgenerate

   logic [PIX_W-1:0]  pix_q;
   logic [LINE_W-1:0] line_q;
   logic              load_w;
   logic              pol_s;
   logic [PIX_W-1:0]  on_s;
   logic [PIX_W-1:0]  off_s;
   logic [CNT_W-1:0]  rem_q;
   logic              line_en;
   logic              act_q;

   spg_timebase #(.PIX_W(PIX_W), .LINE_W(LINE_W), .PIX_MODE(PIX_MODE)) u_tb (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
      .pix_q(pix_q), .line_q(line_q)
   );

   spg_shadow #(.PIX_W(PIX_W), .LINE_W(LINE_W), .CNT_W(CNT_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
      .line_q(line_q), .sg_line(cfg_sg_line),
      .stg_pol(cfg_pol), .stg_set(cfg_tog_set), .stg_clr(cfg_tog_clr),
      .stg_cnt(cfg_pulse_cnt), .stg_sup(cfg_suppress),
      .load(load_w), .pol_s(pol_s), .on_s(on_s), .off_s(off_s), .rem_q(rem_q)
   );

   assign line_en = (rem_q != '0);

   spg_edge #(.PIX_W(PIX_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
      .line_en(line_en), .pix_q(pix_q), .on_s(on_s), .off_s(off_s),
      .pol_s(pol_s), .act_q(act_q), .sub_out(sub_out)
   );
endmodule

// File: rtl/spg_chk.sv
`timescale 1ns/1ps
module spg_chk #(
   parameter int unsigned PIX_W = 8,
   parameter int unsigned LINE_W = 10,
   parameter int unsigned CNT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hsync,
   input logic              vsync,
   input logic              act_q,
   input logic              load,
   input logic              pol_s,
   input logic [PIX_W-1:0]  pix_q,
   input logic [PIX_W-1:0]  on_s,
   input logic [PIX_W-1:0]  off_s,
   input logic [CNT_W-1:0]  rem_q,
   input logic [LINE_W-1:0] line_q,
   input logic [LINE_W-1:0] sg_line
);
   // R4
   set_at_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> ($past(pix_q) == $past(on_s)));

   // R8
   act_needs_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> (rem_q != '0));

   // R7
   vsync_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |=> ((rem_q == '0) && !act_q));

   // R2
   string_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rem_q != '0) && ($past(rem_q) == '0)) |-> ($past(hsync) && ($past(line_q) == $past(sg_line))));

   // R9
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(on_s) && $stable(off_s) && $stable(pol_s)));

   // R5
   equal_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (on_s == off_s) |-> !act_q);
endmodule

bind shutter_pulse_gen spg_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
   .act_q(act_q), .load(load_w), .pol_s(pol_s), .pix_q(pix_q),
   .on_s(on_s), .off_s(off_s), .rem_q(rem_q), .line_q(line_q),
   .sg_line(cfg_sg_line)
);

// File: tb/shutter_pulse_gen_bench.sv
`timescale 1ns/1ps
module shutter_pulse_gen_bench;
   localparam int L  = 32;
   localparam int NL = 12;
   localparam int NV = 8;

   typedef struct packed {
      logic       pol;
      logic [7:0] on;
      logic [7:0] off;
      logic [7:0] cnt;
      logic [9:0] sg;
      logic       sup;
   } vec_t;

   // pol, set, clear, count, sense-gate line, suppress
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'd5,  8'd12, 8'd3, 10'd2, 1'b0},
      '{1'b0, 8'd4,  8'd20, 8'd2, 10'd0, 1'b0},
      '{1'b1, 8'd7,  8'd7,  8'd4, 10'd3, 1'b0},
      '{1'b1, 8'd3,  8'd9,  8'd0, 10'd1, 1'b0},
      '{1'b1, 8'd2,  8'd6,  8'd8, 10'd6, 1'b0},
      '{1'b1, 8'd5,  8'd12, 8'd3, 10'd2, 1'b1},
      '{1'b0, 8'd10, 8'd29, 8'd1, 10'd9, 1'b0},
      '{1'b1, 8'd0,  8'd30, 8'd2, 10'd5, 1'b0}
   };

   function automatic string tag_of(input int i);
      case (i)
         0: return "R2/R3/R4";
         1: return "R6";
         2: return "R5";
         3: return "R3";
         4: return "R7";
         5: return "R8";
         6: return "R6/R2";
         default: return "R4";
      endcase
   endfunction

   logic       clk = 1'b0;
   logic       rst_n;
   logic       hsync, vsync;
   logic       cfg_pol, cfg_suppress;
   logic [7:0] cfg_tog_set, cfg_tog_clr, cfg_pulse_cnt;
   logic [9:0] cfg_sg_line;
   logic       sub_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int meas_w [NL];
   int meas_s [NL];
   int chg_line = -1;
   vec_t pend;

   always #2 clk = ~clk;

   shutter_pulse_gen u_shutter_pulse_gen (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
      .cfg_pol(cfg_pol), .cfg_tog_set(cfg_tog_set), .cfg_tog_clr(cfg_tog_clr),
      .cfg_pulse_cnt(cfg_pulse_cnt), .cfg_suppress(cfg_suppress),
      .cfg_sg_line(cfg_sg_line), .sub_out(sub_out)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      cfg_pol = v.pol;
      cfg_tog_set = v.on;
      cfg_tog_clr = v.off;
      cfg_pulse_cnt = v.cnt;
      cfg_sg_line = v.sg;
      cfg_suppress = v.sup;
   endtask

   // one field; activity measured against the given active level
   task automatic run_field(input logic act_lvl);
      for (int j = 0; j < NL; j++) begin
         if (j == chg_line) apply(pend);
         meas_w[j] = 0;
         meas_s[j] = -1;
         for (int k = 0; k < L; k++) begin
            @(negedge clk);
            if (sub_out === act_lvl) begin
               meas_w[j]++;
               if (meas_s[j] < 0) meas_s[j] = k;
            end
            hsync = (k == 0) && (j != 0);
            vsync = (k == 0) && (j == 0);
         end
      end
   endtask

   task automatic check_field(input vec_t v, input string req);
      for (int j = 0; j < NL; j++) begin
         bit pulsed;
         int ew, es;
         pulsed = !v.sup && (v.cnt != 0) && (v.on != v.off)
                  && (j >= int'(v.sg) + 1) && (j <= int'(v.sg) + int'(v.cnt));
         ew = pulsed ? int'(v.off) - int'(v.on) : 0;
         es = pulsed ? int'(v.on) + 2 : -1;
         check(meas_w[j] == ew, req, $sformatf("line %0d width", j), meas_w[j], ew);
         check(meas_s[j] == es, req, $sformatf("line %0d start", j), meas_s[j], es);
      end
   endtask

   initial begin
      vec_t a, b, quiet;
      rst_n = 1'b0;
      hsync = 1'b0;
      vsync = 1'b0;
      quiet = '{1'b1, 8'd5, 8'd12, 8'd3, 10'd20, 1'b0};
      apply(quiet);
      repeat (4) @(negedge clk);
      // R1: reset level
      check(sub_out === 1'b0, "R1", "output in reset", int'(sub_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(sub_out === 1'b0, "R1", "output after reset", int'(sub_out), 0);
      // R1: no pulse without a start strobe (sense-gate line never reached)
      run_field(1'b1);
      quiet.cnt = 8'd0;
      check_field(quiet, "R1");

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         run_field(VECS[i].pol);
         run_field(VECS[i].pol);
         check_field(VECS[i], tag_of(i));
         run_field(VECS[i].pol);
         check_field(VECS[i], "R10");
      end

      // R9: staged change during a running string
      a = '{1'b1, 8'd5, 8'd12, 8'd3, 10'd2, 1'b0};
      b = '{1'b1, 8'd8, 8'd10, 8'd1, 10'd2, 1'b0};
      apply(a);
      run_field(1'b1);
      pend = b;
      chg_line = 4;
      run_field(1'b1);
      check_field(a, "R9");
      chg_line = -1;
      run_field(1'b1);
      check_field(b, "R9");

      // R8/R9: suppress raised mid-string keeps the current field
      apply(a);
      run_field(1'b1);
      pend = a;
      pend.sup = 1'b1;
      chg_line = 4;
      run_field(1'b1);
      check_field(a, "R9");
      chg_line = -1;
      run_field(1'b1);
      check_field(pend, "R8");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule